// File: doc/BRIEF.md
# Half-Period Baud Clock Generator

This block derives the timing for an asynchronous serial port from the processor clock. Software writes a 16-bit divisor. The divisor gives the number of processor cycles, less one, in each half of a square wave that runs at sixteen times the bit rate. The block drives that square wave and an enable strobe once per full period of it. It also drives a bit-rate strobe once every sixteen periods. With divisor D the bit rate is f / (32 x (D + 1)). D = 0 gives the fastest rate, 1/32 of the processor clock. D = 129 at 40 MHz gives 9615 baud, within 0.2 % of 9600.

The divisor holds no meaningful value after reset, so the block stays silent until the first write. It keeps running between writes and accepts a new divisor at any time. This covers the case where software reprograms it after the processor clock changes speed. Each write restarts the whole timing chain from a clean phase, so the first half period after the write already uses the new value.

Top module: `baud_halfper_gen`

## Requirements
- R1: After reset, `clk16`, `tick16` and `baud_tick` stay 0, however many cycles pass, until the first divisor write.
- R2: After a write of divisor D that is sampled at clock edge 0, `clk16` is 0 and first becomes 1 after edge D+1. It then changes level after every further D+1 edges. That makes its period 2(D+1) cycles.
- R3: `tick16` is high for exactly one cycle per `clk16` period. It rises on the same edge at which `clk16` falls. The first rise after a write comes after edge 2(D+1).
- R4: `baud_tick` is high for single cycles. The first pulse after a write comes after edge 32(D+1), and later pulses follow every 32(D+1) cycles.
- R5: A write issued while the block is running takes effect on the edge that samples it. The cycle after that edge shows all three outputs at 0, and R2 to R4 then apply with the new divisor.
- R6: A write that is sampled on the same edge that would otherwise raise `baud_tick` or `tick16` wins. No strobe appears, and the timing restarts as in R5.
- R7: With D = 0, `tick16` occurs every 2 cycles and `baud_tick` every 32 cycles.
- R8: With D = 129, `baud_tick` pulses are 4160 cycles apart.
- R9: `baud_tick` is high only in cycles where `tick16` is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Divisor write strobe, one cycle |
| div_wdata | input | 16 | Divisor value written when `div_wr` is high |
| clk16 | output | 1 | Square wave at 16x the bit rate |
| tick16 | output | 1 | One-cycle strobe per `clk16` period |
| baud_tick | output | 1 | One-cycle strobe per bit time |

## Verification
Two events can fall on the same edge: a divisor write, and the terminal count that would raise the bit strobe. The bench provokes this on purpose. With D = 1 it issues a second write so that the write is sampled on exactly the edge where the 64th cycle would have produced `baud_tick`. It then requires that no strobe appears and that the timing restarts from zero. A behavioural model expresses every output as a closed-form function of the cycles elapsed since the last write. That model is compared with the design on every clock, so it judges a suppressed strobe and the restarted phase in the same way as normal running.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Width of the software-visible divisor
    parameter int unsigned DIV_W      = 16;
    // Oversampling ratio: periods of clk16 per bit time
    parameter int unsigned OVERSAMPLE = 16;
    localparam int unsigned PER_W     = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [PER_W-1:0] per_t;

    // Divisor holding register state
    typedef struct packed {
        div_t div;
        logic armed;
    } divreg_st_t;

    // Half-period counter state
    typedef struct packed {
        div_t cnt;
    } halfcnt_st_t;

    // Output stage state: wave phase, period count, strobes
    typedef struct packed {
        logic wave;
        per_t per;
        logic tick;
        logic baud;
    } perstage_st_t;

endpackage

// File: rtl/baud_divreg.sv
module baud_divreg
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  div_t wdata,
    output div_t div,
    output logic armed
);

    divreg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.div   = wdata;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            // Divisor content is meaningless until armed is set
            st_q.div   <= '0;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div   = st_q.div;
    assign armed = st_q.armed;

endmodule

// File: rtl/baud_halfcnt.sv
module baud_halfcnt
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic armed,
    input  div_t div,
    output logic half_done
);

    halfcnt_st_t st_d, st_q;
    logic        at_end;

    // Last cycle of a half period: div + 1 cycles per half
    assign at_end    = (st_q.cnt == div);
    assign half_done = armed && !wr && at_end;

    always_comb begin
        st_d = st_q;
        if (wr || !armed) begin
            st_d.cnt = '0;
        end else if (at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + div_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/baud_perstage.sv
module baud_perstage
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic half_done,
    output logic wave,
    output logic tick,
    output logic baud
);

    localparam per_t PER_LAST = per_t'(OVERSAMPLE - 1);

    perstage_st_t st_d, st_q;
    logic         period_end;
    logic         bit_end;

    // A full period closes when the wave leaves its high half
    assign period_end = half_done && st_q.wave;

    generate
        if (OVERSAMPLE > 1) begin : g_multi
            assign bit_end = period_end && (st_q.per == PER_LAST);
        end else begin : g_single
            assign bit_end = period_end;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.baud = 1'b0;
        if (wr) begin
            st_d.wave = 1'b0;
            st_d.per  = '0;
        end else if (half_done) begin
            st_d.wave = !st_q.wave;
            if (period_end) begin
                st_d.tick = 1'b1;
                st_d.baud = bit_end;
                st_d.per  = bit_end ? '0 : st_q.per + per_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wave <= 1'b0;
            st_q.per  <= '0;
            st_q.tick <= 1'b0;
            st_q.baud <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave = st_q.wave;
    assign tick = st_q.tick;
    assign baud = st_q.baud;

endmodule

// File: rtl/baud_halfper_gen.sv
module baud_halfper_gen
    import baud_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        div_wr,
    input  logic [15:0] div_wdata,
    output logic        clk16,
    output logic        tick16,
    output logic        baud_tick
);

    div_t div;
    logic armed;
    logic half_done;

    baud_divreg u_divreg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (div_wr),
        .wdata (div_t'(div_wdata)),
        .div   (div),
        .armed (armed)
    );

    baud_halfcnt u_halfcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (div_wr),
        .armed     (armed),
        .div       (div),
        .half_done (half_done)
    );

    baud_perstage u_perstage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (div_wr),
        .half_done (half_done),
        .wave      (clk16),
        .tick      (tick16),
        .baud      (baud_tick)
    );

endmodule

// File: rtl/baud_halfper_gen_chk.sv
module baud_halfper_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic div_wr,
    input logic clk16,
    input logic tick16,
    input logic baud_tick
);

    logic written_q;

    always_ff @(posedge clk) begin
        if (!rst_n) written_q <= 1'b0;
        else if (div_wr) written_q <= 1'b1;
    end

    // R1
    silent_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !written_q |-> (!clk16 && !tick16 && !baud_tick));

    // R3
    tick_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |-> $fell(clk16));

    // R4
    baud_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    // R5
    write_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (!clk16 && !tick16 && !baud_tick));

    // R9
    baud_within_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> tick16);

endmodule

bind baud_halfper_gen baud_halfper_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_wr    (div_wr),
    .clk16     (clk16),
    .tick16    (tick16),
    .baud_tick (baud_tick)
);

// File: tb/baud_halfper_gen_bench.sv
module baud_halfper_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_wr = 1'b0;
    logic [15:0] div_wdata = '0;
    logic        clk16, tick16, baud_tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_halfper_gen u_baud_halfper_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .clk16     (clk16),
        .tick16    (tick16),
        .baud_tick (baud_tick)
    );

    // Reference model: outputs as closed-form functions of edges since write
    int  m_armed = 0;
    longint m_t = 0;
    longint m_div = 0;
    longint cyc = 0;
    longint last_baud = -1;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_armed = 0;
            m_t = 0;
            last_baud = -1;
        end else if (div_wr) begin
            m_armed = 1;
            m_div = longint'(div_wdata);
            m_t = 0;
            last_baud = -1;
        end else if (m_armed != 0) begin
            m_t = m_t + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            longint h, e_clk, e_tick, e_baud;
            h = m_div + 1;
            e_clk  = (m_armed != 0 && ((m_t / h) % 2) == 1) ? 1 : 0;
            e_tick = (m_armed != 0 && m_t > 0 && (m_t % (2*h)) == 0) ? 1 : 0;
            e_baud = (m_armed != 0 && m_t > 0 && (m_t % (32*h)) == 0) ? 1 : 0;
            check("R2", "clk16", longint'(clk16), e_clk);
            check("R3", "tick16", longint'(tick16), e_tick);
            check("R4", "baud_tick", longint'(baud_tick), e_baud);
            if (baud_tick) begin
                check("R9", "tick16 with baud_tick", longint'(tick16), 1);
                if (last_baud >= 0) begin
                    if (m_div == 0)
                        check("R7", "baud spacing D=0", cyc - last_baud, 32);
                    else if (m_div == 129)
                        check("R8", "baud spacing D=129", cyc - last_baud, 4160);
                    else
                        check("R4", "baud spacing", cyc - last_baud, 32*h);
                end
                last_baud = cyc;
            end
        end
    end

    task automatic wr_div(input int val);
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = 16'(val);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset without any write
        repeat (40) @(negedge clk);
        check("R1", "clk16 idle", longint'(clk16), 0);
        check("R1", "tick16 idle", longint'(tick16), 0);
        check("R1", "baud_tick idle", longint'(baud_tick), 0);

        // R7: fastest rate
        wr_div(0);
        check("R5", "clk16 after write", longint'(clk16), 0);
        repeat (100) @(negedge clk);

        // R5: rewrite while running, D=1
        wr_div(1);
        check("R5", "tick16 after write", longint'(tick16), 0);
        repeat (200) @(negedge clk);

        // R6: write sampled on the edge that would raise baud_tick (t=64)
        wr_div(1);
        repeat (62) @(negedge clk);
        wr_div(1);
        check("R6", "baud_tick suppressed", longint'(baud_tick), 0);
        check("R6", "tick16 suppressed", longint'(tick16), 0);
        repeat (70) @(negedge clk);

        // R8: 9600 baud setting at 40 MHz
        wr_div(129);
        repeat (8400) @(negedge clk);

        // R5: change divisor mid-run, as after a clock speed change
        repeat (1000) @(negedge clk);
        wr_div(3);
        check("R5", "baud_tick after rewrite", longint'(baud_tick), 0);
        repeat (400) @(negedge clk);

        finish_run();
    end

endmodule